// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block holds a colour lookup table of 256 entries, each an 18-bit colour made of three 6-bit components. A processor reaches it through four byte-wide registers. One register sets the entry to be loaded and another sets the entry to be read back. The third is a data port that moves one colour component per access. The fourth is a pixel mask. On the display side, an 8-bit pixel index is masked and looked up on every clock, and the 18-bit colour comes out one cycle later.

The processor loads an entry by writing its number to the load-index register. It then writes the data port three times, giving red, then green, then blue. Red and green are held in staging registers. The entry is written in one step when blue arrives. The load index then moves to the next entry and the component counter goes back to red, so a run of entries can be streamed without writing the index again. Reading works the same way from the read-index register. To blank the screen, all three components of the first sixteen entries are set to zero.

Top module: `clut_port`

## Requirements
- R1: After reset, the pixel colour output is 0, the mask reads 0xFF, both index registers read 0, the component counter is at red and every entry holds 0.
- R2: Register codes on `cpu_addr` are 0 for the load index, 1 for the data port, 2 for the read index and 3 for the mask. After the load index is written, the next three data-port writes supply red, green and blue. The entry does not change until the blue write.
- R3: After the blue write, the load index is one higher (255 wraps to 0) and the component counter returns to red.
- R4: A write to either index register returns the component counter to red and discards any red or green already staged.
- R5: After the read index is written, three data-port reads return red, green and blue of that entry in that order. After the blue read, the read index is one higher.
- R6: Only the low 6 bits of a data-port write are stored. Data-port reads return 0 in bits 7:6.
- R7: The entry looked up is `pix_idx` AND the mask register.
- R8: `pix_rgb` = {red, green, blue} (red in bits 17:12, blue in bits 5:0) of the looked-up entry. It appears on the clock edge after `pix_idx` is presented.
- R9: `cpu_rdata` is loaded on the clock edge that samples `cpu_rd`. Addresses 0, 2 and 3 return the load index, the read index and the mask. When `cpu_wr` and `cpu_rd` are both high, the read is ignored.
- R10: Writing zero to all three components of entries 0 to 15 makes every pixel index in 0 to 15 produce colour 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 18 | Looked-up colour {R,G,B} |

## Verification
A register write takes effect on the edge that samples it. An entry written by a blue write can be seen by a pixel lookup starting on the next cycle. Read data and pixel colour each arrive one edge after the strobe or index is applied. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the edge that produced the result. It also samples just before that edge, to confirm that the pixel output does not yet show a new index.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  localparam logic [1:0] A_WIDX = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_RIDX = 2'd2;
  localparam logic [1:0] A_MASK = 2'd3;

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [IDX_W-1:0]  wr_ptr,
  output logic [IDX_W-1:0]  rd_ptr,
  output phase_t            phase,
  output logic              ram_we,
  output logic [3*COMP_W-1:0] ram_wdata
);
  logic [COMP_W-1:0] stg_r, stg_g;

  // Named access events, shared with the assertions
  logic widx_ld, ridx_ld, dat_wr, dat_rd, step;
  assign widx_ld = cpu_wr && cpu_addr == A_WIDX;
  assign ridx_ld = cpu_wr && cpu_addr == A_RIDX;
  assign dat_wr  = cpu_wr && cpu_addr == A_DATA;
  assign dat_rd  = cpu_rd && !cpu_wr && cpu_addr == A_DATA;
  assign step    = dat_wr || dat_rd;

  assign ram_we    = dat_wr && phase == PH_BLU;
  assign ram_wdata = {stg_r, stg_g, cpu_wdata[COMP_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_RED;
      wr_ptr <= '0;
      rd_ptr <= '0;
      stg_r  <= '0;
      stg_g  <= '0;
    end else begin
      if (widx_ld || ridx_ld)
        phase <= PH_RED;
      else if (step)
        phase <= next_phase(phase);

      if (widx_ld)
        wr_ptr <= cpu_wdata[IDX_W-1:0];
      else if (ram_we)
        wr_ptr <= wr_ptr + 1'b1;

      if (ridx_ld)
        rd_ptr <= cpu_wdata[IDX_W-1:0];
      else if (dat_rd && phase == PH_BLU)
        rd_ptr <= rd_ptr + 1'b1;

      if (dat_wr && phase == PH_RED) stg_r <= cpu_wdata[COMP_W-1:0];
      if (dat_wr && phase == PH_GRN) stg_g <= cpu_wdata[COMP_W-1:0];
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R3
  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && phase == PH_BLU) |=> (phase == PH_RED && wr_ptr == $past(wr_ptr) + 1'b1)); // R3
  AST_IDX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (widx_ld || ridx_ld) |=> phase == PH_RED); // R4
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && phase == PH_BLU) |=> rd_ptr == $past(rd_ptr) + 1'b1); // R5
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] cpu_raddr,
  output logic [ENT_W-1:0] cpu_rentry,
  input  logic [IDX_W-1:0] pix_addr,
  output logic [ENT_W-1:0] pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[i] <= '0;
      else if (we && waddr == IDX_W'(i))
        ent[i] <= wdata;
    end
  end

  assign cpu_rentry = ent[cpu_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= ent[pix_addr];
  end
endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  input  logic [1:0]          cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int ENT_W = 3 * COMP_W;

  logic [IDX_W-1:0] wr_ptr, rd_ptr, pix_mask, pix_addr;
  phase_t           phase;
  logic             ram_we;
  logic [ENT_W-1:0] ram_wdata, cpu_rentry;
  logic             rd_ev, mask_ld;

  assign rd_ev    = cpu_rd && !cpu_wr;
  assign mask_ld  = cpu_wr && cpu_addr == A_MASK;
  assign pix_addr = masked_index(pix_idx, pix_mask);

  function automatic logic [IDX_W-1:0] masked_index(input logic [IDX_W-1:0] idx,
                                                    input logic [IDX_W-1:0] msk);
    return idx & msk;
  endfunction

  function automatic logic [COMP_W-1:0] comp_of(input logic [ENT_W-1:0] e, input phase_t p);
    case (p)
      PH_RED:  return e[3*COMP_W-1:2*COMP_W];
      PH_GRN:  return e[2*COMP_W-1:COMP_W];
      default: return e[COMP_W-1:0];
    endcase
  endfunction

  clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .phase(phase), .ram_we(ram_we), .ram_wdata(ram_wdata)
  );

  clut_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(wr_ptr), .wdata(ram_wdata),
    .cpu_raddr(rd_ptr), .cpu_rentry(cpu_rentry), .pix_addr(pix_addr),
    .pix_rgb(pix_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_mask  <= '1;
      cpu_rdata <= '0;
    end else begin
      if (mask_ld) pix_mask <= cpu_wdata[IDX_W-1:0];
      if (rd_ev) begin
        case (cpu_addr)
          A_WIDX:  cpu_rdata <= DATA_W'(wr_ptr);
          A_DATA:  cpu_rdata <= DATA_W'(comp_of(cpu_rentry, phase));
          A_RIDX:  cpu_rdata <= DATA_W'(rd_ptr);
          default: cpu_rdata <= DATA_W'(pix_mask);
        endcase
      end
    end
  end

  AST_RDATA_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && cpu_addr == A_DATA) |=> cpu_rdata[DATA_W-1:COMP_W] == '0); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_ld |=> $stable(pix_mask)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(cpu_rdata)); // R9
endmodule

// File: tb/sim_clut_port.sv
`timescale 1ns/1ps
module sim_clut_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [7:0]  pix_idx = '0;
  logic [17:0] pix_rgb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clut_port u0 (.clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic pix(input logic [7:0] i, output logic [17:0] c);
    @(negedge clk); pix_idx = i;
    @(negedge clk); c = pix_rgb;
  endtask

  task automatic load(input logic [7:0] i, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    bus_wr(2'd0, i); bus_wr(2'd1, r); bus_wr(2'd1, g); bus_wr(2'd1, b);
  endtask

  function automatic logic [17:0] rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {r[5:0], g[5:0], b[5:0]};
  endfunction

  task automatic t_reset();
    logic [7:0] d; logic [17:0] c;
    chk("R1 pix", pix_rgb, 0);
    bus_rd(2'd3, d); chk("R1 mask", d, 8'hFF);
    bus_rd(2'd0, d); chk("R1 widx", d, 0);
    bus_rd(2'd2, d); chk("R1 ridx", d, 0);
    pix(8'd200, c);  chk("R1 entry", c, 0);
  endtask

  task automatic t_load();
    logic [7:0] d; logic [17:0] c;
    load(8'd5, 8'h3F, 8'h15, 8'h2A);
    pix(8'd5, c); chk("R2 R8 load", c, rgb(8'h3F, 8'h15, 8'h2A));
    bus_rd(2'd0, d); chk("R3 widx step", d, 8'd6);
    bus_wr(2'd1, 8'h01); bus_wr(2'd1, 8'h02); bus_wr(2'd1, 8'h03);
    pix(8'd6, c); chk("R3 stream", c, rgb(8'h01, 8'h02, 8'h03));
  endtask

  task automatic t_partial();
    logic [17:0] c;
    bus_wr(2'd0, 8'd9); bus_wr(2'd1, 8'h11); bus_wr(2'd1, 8'h22);
    pix(8'd9, c); chk("R2 staged", c, 0);
    bus_wr(2'd0, 8'd9);
    bus_wr(2'd1, 8'h07); bus_wr(2'd1, 8'h08); bus_wr(2'd1, 8'h09);
    pix(8'd9, c); chk("R4 widx reset", c, rgb(8'h07, 8'h08, 8'h09));
    bus_wr(2'd0, 8'd10); bus_wr(2'd1, 8'h33);
    bus_wr(2'd2, 8'd0);
    bus_wr(2'd1, 8'h04); bus_wr(2'd1, 8'h05); bus_wr(2'd1, 8'h06);
    pix(8'd10, c); chk("R4 ridx reset", c, rgb(8'h04, 8'h05, 8'h06));
  endtask

  task automatic t_wrap();
    logic [7:0] d; logic [17:0] c;
    load(8'd255, 8'h2B, 8'h2C, 8'h2D);
    bus_rd(2'd0, d); chk("R3 wrap", d, 0);
    pix(8'd255, c); chk("R3 last entry", c, rgb(8'h2B, 8'h2C, 8'h2D));
  endtask

  task automatic t_upper();
    logic [17:0] c;
    load(8'd20, 8'hFF, 8'hC1, 8'h80);
    pix(8'd20, c); chk("R6 upper bits", c, rgb(8'h3F, 8'h01, 8'h00));
  endtask

  task automatic t_read();
    logic [7:0] d;
    bus_wr(2'd2, 8'd5);
    bus_rd(2'd1, d); chk("R5 red", d, 8'h3F);
    bus_rd(2'd1, d); chk("R5 green", d, 8'h15);
    bus_rd(2'd1, d); chk("R5 blue", d, 8'h2A);
    bus_rd(2'd2, d); chk("R5 ridx step", d, 8'd6);
    bus_rd(2'd1, d); chk("R5 next red", d, 8'h01);
    bus_wr(2'd2, 8'd20);
    bus_rd(2'd1, d); chk("R6 read hi zero", d, 8'h3F);
    @(negedge clk); cpu_wr = 1; cpu_rd = 1; cpu_addr = 2'd3; cpu_wdata = 8'hFF;
    @(negedge clk); cpu_wr = 0; cpu_rd = 0;
    chk("R9 rd ignored", cpu_rdata, 8'h3F);
    bus_rd(2'd1, d); chk("R9 counter held", d, 8'h01);
  endtask

  task automatic t_mask();
    logic [7:0] d; logic [17:0] c;
    bus_wr(2'd3, 8'h0F);
    bus_rd(2'd3, d); chk("R9 mask rb", d, 8'h0F);
    pix(8'h25, c); chk("R7 mask 25", c, rgb(8'h3F, 8'h15, 8'h2A));
    pix(8'h14, c); chk("R7 mask 14", c, 0);
    bus_wr(2'd3, 8'hFF);
    pix(8'h14, c); chk("R7 unmasked", c, rgb(8'h3F, 8'h01, 8'h00));
  endtask

  task automatic t_latency();
    logic [17:0] c;
    pix(8'd5, c);
    @(negedge clk); pix_idx = 8'd6;
    #2.0; chk("R8 before edge", pix_rgb, rgb(8'h3F, 8'h15, 8'h2A));
    @(negedge clk); chk("R8 after edge", pix_rgb, rgb(8'h01, 8'h02, 8'h03));
  endtask

  task automatic t_blank();
    logic [17:0] c;
    bus_wr(2'd0, 8'd0);
    for (int k = 0; k < 48; k++) bus_wr(2'd1, 8'h00);
    for (int k = 0; k < 16; k++) begin
      pix(8'(k), c); chk("R10 blank", c, 0);
    end
    pix(8'd20, c); chk("R10 beyond", c, rgb(8'h3F, 8'h01, 8'h00));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_load(); t_partial(); t_wrap(); t_upper();
    t_read(); t_mask(); t_latency(); t_blank();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule